// File: doc/BRIEF.md
# Interruptible DDR Read Burst Scheduler

This block is the device-side read scheduler of a double-data-rate memory. One command is taken on every clock. The block turns each read into a burst of column addresses, and it places those addresses on the data bus after the CAS latency. A clock cycle carries two beats: the rise beat goes out on the rising edge and the fall beat on the falling edge. The data word of each beat is a fixed function of its bank and column, and it stands in for the contents of the array.

A later read cuts short the burst that is still in flight. It waits for its own latency. Until then, the beats of the earlier burst keep going out. From then on, a full burst of the new read takes the bus. A burst stop command frees the bus a CAS latency after it is issued. The block also flags a strobe preamble before a burst that starts from an idle bus, and a postamble after the last driven cycle.

Top module: `ddr_rd_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_oe`, `strobe_pre` and `strobe_post` are low.
- R2: The command codes are 1 for READ and 2 for READ with autoprecharge. A READ issued in cycle c drives `bus_oe` high in cycle c+CL. `beat_bank` carries the bank, and `rise_col`/`fall_col` carry two consecutive beats. Each data word equals the all-ones DW-bit value minus (bank * 2^COL_W + beat column), truncated to DW bits.
- R3: `cfg_bl` 0, 1 and 2 select bursts of 2, 4 and 8 beats, and 3 behaves as 8. Beat k of a burst takes its column from the aligned block that holds the start column, at offset (start + k) mod BL. The burst lasts BL/2 cycles.
- R4: `cfg_cl3` = 0 selects a CAS latency of 2 cycles, and 1 selects 3 cycles.
- R5: A read issued while an earlier burst is in flight does not touch the bus until its own latency expires. In that cycle its beat 0 and beat 1 replace the remaining beats of the earlier burst, and its full burst follows.
- R6: Reads may be one clock apart. With BL 4, the first read's beats 0 and 1 are followed directly by all four beats of the second read.
- R7: The code for BURST STOP is 4. A stop issued in cycle s leaves the bus undriven from cycle s+CL onward, until a later read takes effect. Beats scheduled for cycles before s+CL are still delivered.
- R8: `strobe_pre` is high in cycle c+CL-1 for a READ issued in cycle c, but only when the bus is not driven in that cycle.
- R9: `strobe_post` is high in any cycle in which the bus is not driven but was driven in the cycle before.
- R10: READ with autoprecharge schedules data exactly like READ. WRITE (3), NOP (0) and the codes 5 to 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl3 | input | 1 | CAS latency select (0: 2, 1: 3) |
| cfg_bl | input | 2 | Burst length select (0: 2, 1: 4, else 8) |
| cmd | input | 3 | Command code for this cycle |
| cmd_bank | input | BANK_W | Bank of a read |
| cmd_col | input | COL_W | Start column of a read |
| bus_oe | output | 1 | Data bus driven in this cycle |
| beat_bank | output | BANK_W | Bank of the beats in this cycle |
| rise_col | output | COL_W | Column of the rising-edge beat |
| fall_col | output | COL_W | Column of the falling-edge beat |
| rise_data | output | DW | Data of the rising-edge beat |
| fall_data | output | DW | Data of the falling-edge beat |
| strobe_pre | output | 1 | Strobe preamble cycle |
| strobe_post | output | 1 | Strobe postamble cycle |

## Verification
Two events can land in the same cycle. In the first case, a new read's latency expires while an older burst still has beats to send, and the new read must take those beats over. In the second case, a burst ends one idle cycle before the next one starts, so the postamble of the first and the preamble of the second fall together. The bench provokes both by sweeping the gap between two reads from one to five clocks under every latency and burst length. It also moves a burst stop across the active burst. A bench model works out, from command indices alone, which read owns each cycle, and it judges every cycle's bus state, columns, data and amble flags against that model.

// File: rtl/ddrsch_pkg.sv
package ddrsch_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDA  = 3'd2,
    CMD_WR   = 3'd3,
    CMD_STOP = 3'd4
  } cmd_e;

  localparam int COL_MAX_W = 16;

  // beats in one burst for a length code
  function automatic logic [3:0] burst_len(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // column of beat idx inside the aligned block of len beats
  function automatic logic [COL_MAX_W-1:0] wrap_col(input logic [COL_MAX_W-1:0] start,
                                                    input logic [3:0] idx,
                                                    input logic [3:0] len);
    logic [COL_MAX_W-1:0] m;
    m = COL_MAX_W'(len) - 1'b1;
    return (start & ~m) | ((start + COL_MAX_W'(idx)) & m);
  endfunction

endpackage

// File: rtl/ddrsch_cmd_delay.sv
module ddrsch_cmd_delay
  import ddrsch_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl3,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  output logic              launch,
  output logic              stop_hit,
  output logic              pre_hit,
  output logic [BANK_W-1:0] l_bank,
  output logic [COL_W-1:0]  l_col
);

  localparam int MAX_CL = 3;
  localparam int DLY    = MAX_CL - 1;

  logic              is_rd, is_stop;
  logic [DLY-1:0]    rd_q, st_q;
  logic [BANK_W-1:0] bk_q [DLY];
  logic [COL_W-1:0]  cq_q [DLY];
  logic              tap;

  assign is_rd   = (cmd_e'(cmd) == CMD_RD) || (cmd_e'(cmd) == CMD_RDA);
  assign is_stop = (cmd_e'(cmd) == CMD_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      st_q <= '0;
      for (int i = 0; i < DLY; i++) begin
        bk_q[i] <= '0;
        cq_q[i] <= '0;
      end
    end else begin
      rd_q[0] <= is_rd;
      st_q[0] <= is_stop;
      bk_q[0] <= bank;
      cq_q[0] <= col;
      for (int i = 1; i < DLY; i++) begin
        rd_q[i] <= rd_q[i-1];
        st_q[i] <= st_q[i-1];
        bk_q[i] <= bk_q[i-1];
        cq_q[i] <= cq_q[i-1];
      end
    end
  end

  // stage index for the selected latency: CL-2
  assign tap      = cl3;
  assign launch   = rd_q[tap];
  assign stop_hit = st_q[tap];
  assign l_bank   = bk_q[tap];
  assign l_col    = cq_q[tap];
  // one cycle ahead of launch
  assign pre_hit  = cl3 ? rd_q[0] : is_rd;

endmodule

// File: rtl/ddrsch_burst_gen.sv
module ddrsch_burst_gen
  import ddrsch_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bl_code,
  input  logic              launch,
  input  logic              stop_hit,
  input  logic [BANK_W-1:0] l_bank,
  input  logic [COL_W-1:0]  l_col,
  output logic              emit,
  output logic              oe,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col0_o,
  output logic [COL_W-1:0]  col1_o,
  output logic [DW-1:0]     dat0_o,
  output logic [DW-1:0]     dat1_o
);

  function automatic logic [DW-1:0] beat_word(input logic [BANK_W-1:0] b,
                                              input logic [COL_W-1:0] c);
    return ~DW'({b, c});
  endfunction

  logic [3:0]        len;
  logic              act_q, n_act;
  logic [3:0]        idx_q, n_idx, b_idx;
  logic [BANK_W-1:0] bank_q, n_bank;
  logic [COL_W-1:0]  col_q, n_col;
  logic [COL_W-1:0]  c0, c1;

  assign len = burst_len(bl_code);

  always_comb begin
    emit   = 1'b0;
    n_act  = 1'b0;
    n_idx  = idx_q;
    n_bank = bank_q;
    n_col  = col_q;
    b_idx  = idx_q;
    if (launch) begin
      emit   = 1'b1;
      n_bank = l_bank;
      n_col  = l_col;
      b_idx  = 4'd0;
      n_idx  = 4'd2;
      n_act  = (len > 4'd2);
    end else if (stop_hit) begin
      emit  = 1'b0;
      n_act = 1'b0;
    end else if (act_q) begin
      emit  = 1'b1;
      n_idx = idx_q + 4'd2;
      n_act = ((idx_q + 4'd2) < len);
    end
    c0 = COL_W'(wrap_col(COL_MAX_W'(n_col), b_idx, len));
    c1 = COL_W'(wrap_col(COL_MAX_W'(n_col), b_idx + 4'd1, len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
      oe     <= 1'b0;
      col0_o <= '0;
      col1_o <= '0;
      dat0_o <= '0;
      dat1_o <= '0;
    end else begin
      act_q  <= n_act;
      idx_q  <= n_idx;
      bank_q <= n_bank;
      col_q  <= n_col;
      oe     <= emit;
      col0_o <= emit ? c0 : '0;
      col1_o <= emit ? c1 : '0;
      dat0_o <= emit ? beat_word(n_bank, c0) : '0;
      dat1_o <= emit ? beat_word(n_bank, c1) : '0;
    end
  end

  assign bank_o = bank_q;

  a_r5_launch_drives: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> oe);
  a_r7_stop_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !launch) |=> !oe);
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= len);
  a_r5_continue: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !launch && !stop_hit) |=> oe);

endmodule

// File: rtl/ddrsch_amble.sv
module ddrsch_amble (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_hit,
  input  logic emit,
  input  logic oe_now,
  output logic pre_q,
  output logic post_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= 1'b0;
      post_q <= 1'b0;
    end else begin
      pre_q  <= pre_hit && !emit;
      post_q <= oe_now && !emit;
    end
  end

  a_r8_pre_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q |-> !oe_now);
  a_r9_post_follows: assert property (@(posedge clk) disable iff (!rst_n)
    post_q |-> (!oe_now && $past(oe_now)));

endmodule

// File: rtl/ddr_rd_sched.sv
module ddr_rd_sched
  import ddrsch_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cl3,
  input  logic [1:0]        cfg_bl,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              bus_oe,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  rise_col,
  output logic [COL_W-1:0]  fall_col,
  output logic [DW-1:0]     rise_data,
  output logic [DW-1:0]     fall_data,
  output logic              strobe_pre,
  output logic              strobe_post
);

  logic              launch, stop_hit, pre_hit, emit;
  logic [BANK_W-1:0] l_bank;
  logic [COL_W-1:0]  l_col;

  initial begin
    if (COL_W > COL_MAX_W) $error("COL_W too wide");
  end

  ddrsch_cmd_delay #(.BANK_W(BANK_W), .COL_W(COL_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .cl3(cfg_cl3), .cmd(cmd), .bank(cmd_bank), .col(cmd_col),
    .launch(launch), .stop_hit(stop_hit), .pre_hit(pre_hit), .l_bank(l_bank), .l_col(l_col)
  );

  ddrsch_burst_gen #(.BANK_W(BANK_W), .COL_W(COL_W), .DW(DW)) u_gen (
    .clk(clk), .rst_n(rst_n), .bl_code(cfg_bl), .launch(launch), .stop_hit(stop_hit),
    .l_bank(l_bank), .l_col(l_col), .emit(emit), .oe(bus_oe), .bank_o(beat_bank),
    .col0_o(rise_col), .col1_o(fall_col), .dat0_o(rise_data), .dat1_o(fall_data)
  );

  ddrsch_amble u_amb (
    .clk(clk), .rst_n(rst_n), .pre_hit(pre_hit), .emit(emit), .oe_now(bus_oe),
    .pre_q(strobe_pre), .post_q(strobe_post)
  );

  a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> (!bus_oe && !strobe_pre && !strobe_post));

endmodule

// File: tb/tb_ddr_rd_sched.sv
module tb_ddr_rd_sched;

  localparam int NC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cl3 = 1'b0;
  logic [1:0] cfg_bl = 2'd0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] cmd_bank = '0;
  logic [9:0] cmd_col = '0;
  logic       bus_oe, strobe_pre, strobe_post;
  logic [1:0] beat_bank;
  logic [9:0] rise_col, fall_col;
  logic [15:0] rise_data, fall_data;

  int checks = 0;
  int fails = 0;
  int cl = 2;
  int blen = 2;
  int scmd [NC];
  int sbank [NC];
  int scol [NC];

  always #4 clk = ~clk;

  ddr_rd_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl), .cmd(cmd),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .bus_oe(bus_oe), .beat_bank(beat_bank),
    .rise_col(rise_col), .fall_col(fall_col), .rise_data(rise_data), .fall_data(fall_data),
    .strobe_pre(strobe_pre), .strobe_post(strobe_post)
  );

  task automatic chk(input string tag, input string what, input int c,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d cl=%0d bl=%0d act=%0h exp=%0h", tag, what, c, cl, blen, act, exp);
    end
  endtask

  function automatic bit is_read(int c);
    if (c < 0 || c >= NC) return 1'b0;
    return (scmd[c] == 1) || (scmd[c] == 2);
  endfunction

  // index of the read owning the bus in cycle k, or -1
  function automatic int owner(int k);
    int r = -1;
    int s = -1;
    for (int j = 0; j <= k - cl; j++) begin
      if (is_read(j)) r = j;
      if (scmd[j] == 4) s = j;
    end
    if (r < 0 || s > r) return -1;
    if (2 * (k - cl - r) >= blen) return -1;
    return r;
  endfunction

  function automatic int beat_col(int start, int i);
    return (start / blen) * blen + ((start % blen) + i) % blen;
  endfunction

  function automatic int word(int b, int c);
    return 65535 - (b * 1024 + c);
  endfunction

  task automatic clr();
    for (int i = 0; i < NC; i++) begin
      scmd[i] = 0; sbank[i] = 0; scol[i] = 0;
    end
  endtask

  task automatic put(int c, int op, int b, int col);
    scmd[c] = op; sbank[c] = b; scol[c] = col;
  endtask

  task automatic run_scn(input string tag);
    rst_n = 1'b0;
    cmd = 3'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NC; c++) begin
      int r, r1, i;
      bit oe_e, oe_p;
      if (c > 0) @(negedge clk);
      r = owner(c);
      oe_e = (r >= 0);
      chk(tag, "oe", c, longint'(bus_oe), longint'(oe_e));
      if (oe_e) begin
        i = 2 * (c - cl - r);
        chk(tag, "bank", c, longint'(beat_bank), longint'(sbank[r]));
        chk(tag, "rise_col", c, longint'(rise_col), longint'(beat_col(scol[r], i)));
        chk(tag, "fall_col", c, longint'(fall_col), longint'(beat_col(scol[r], i + 1)));
        chk(tag, "rise_data", c, longint'(rise_data), longint'(word(sbank[r], beat_col(scol[r], i))));
        chk(tag, "fall_data", c, longint'(fall_data), longint'(word(sbank[r], beat_col(scol[r], i + 1))));
      end
      chk("R8", "pre", c, longint'(strobe_pre), longint'(!oe_e && is_read(c + 1 - cl)));
      r1 = (c >= 1) ? owner(c - 1) : -1;
      oe_p = (r1 >= 0);
      chk("R9", "post", c, longint'(strobe_post), longint'(oe_p && !oe_e));
      cmd = 3'(scmd[c]);
      cmd_bank = 2'(sbank[c]);
      cmd_col = 10'(scol[c]);
    end
    cmd = 3'd0;
  endtask

  initial begin
    // R1: outputs quiet during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "oe_in_reset", 0, longint'(bus_oe), 0);
    chk("R1", "pre_in_reset", 0, longint'(strobe_pre), 0);
    chk("R1", "post_in_reset", 0, longint'(strobe_post), 0);
    for (int ci = 0; ci < 2; ci++) begin
      for (int bc = 0; bc < 3; bc++) begin
        cfg_cl3 = ci[0];
        cfg_bl = 2'(bc);
        cl = 2 + ci;
        blen = 2 << bc;
        // R2 / R4: single aligned read
        clr(); put(1, 1, 1, 40);
        run_scn(ci == 1 ? "R4" : "R2");
        // R3: unaligned start wraps inside its block
        clr(); put(0, 1, 2, 1021);
        run_scn("R3");
        // R5 / R6: second read at growing distance
        for (int g = 1; g <= 5; g++) begin
          clr(); put(0, 1, 0, 100); put(g, 1, 3, 515);
          run_scn(g == 1 ? "R6" : "R5");
        end
        // R7: burst stop at several points of the burst
        for (int g = 1; g <= 3; g++) begin
          clr(); put(0, 1, 1, 12); put(g, 4, 0, 0);
          run_scn("R7");
        end
        // R10: autoprecharge read, write and unused codes
        clr(); put(0, 2, 2, 7); put(1, 3, 1, 3); put(2, 7, 3, 9);
        put(3, 5, 0, 1); put(4, 6, 1, 2); put(9, 1, 1, 333); put(10, 3, 2, 4);
        run_scn("R10");
      end
    end
    // R3: length code 3 behaves as 8
    cfg_cl3 = 1'b0; cfg_bl = 2'd3; cl = 2; blen = 8;
    clr(); put(0, 1, 3, 1019);
    run_scn("R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule